// File: doc/BRIEF.md
# Caliper Binary Frame Receiver

This block takes the two-wire synchronous serial output of a digital measuring scale that reports its position as binary words. The scale drives a clock line and a data line; both arrive here as already-digitised levels, unrelated to the system clock. The receiver brings both lines into the system clock domain and finds the start of a burst from the line timing. It then collects 48 bits on falling edges of the scale clock: a 24-bit absolute position followed by a 24-bit relative (displayed) position. One count of either word equals 1/20480 inch.

Timing framing works in two steps. The receiver first needs the scale clock to stay low for a long idle period (about 1 ms on a real scale; a parameter in system cycles). Only then is it armed. Once armed, a burst begins at the first falling edge that follows a clock-high stretch of at least the gap length (about 50 µs on a real scale; a parameter). The scale clock cannot be paused, so the word output cannot push back on the scale. The output is a valid/ready stream whose words are held until they are taken. If a newer frame completes while words are still pending, the newer words replace them. If the clock sits low for the idle length before all 48 bits have arrived, the partial frame is discarded and a one-cycle error pulse is raised.

Top module: `cal_bin_rx`

## Requirements
- R1: After reset, out_valid is 0, frame_err is 0, and abs_pos and rel_pos are 0.
- R2: After reset, and after every completed frame, the receiver ignores all falling edges until the synchronised scale clock has been low for IDLE_CYC consecutive system cycles.
- R3: Once armed, a frame starts only at a falling edge that follows at least GAP_CYC system cycles of clock high. Falling edges after shorter high pulses are ignored, and the receiver stays armed.
- R4: Each bit is the data level sampled at a falling edge of the scale clock. Bit n of the burst (n = 0..47) goes to abs_pos[n] for n < 24 and to rel_pos[n-24] for n >= 24, so each word is least significant bit first and absolute comes first.
- R5: When the 48th bit arrives, abs_pos and rel_pos update together and out_valid goes to 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and abs_pos and rel_pos do not change, unless a new frame completes.
- R7: A frame that completes while words are still pending replaces both words, and out_valid stays 1.
- R8: When out_valid and out_ready are both 1 at a clock edge, out_valid is 0 after that edge (when no new frame completes in the same cycle).
- R9: If the clock stays low for IDLE_CYC cycles during a frame, frame_err pulses for exactly one cycle, the partial frame is dropped without raising out_valid, and the receiver is armed for the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_clk | input | 1 | Scale clock line, asynchronous level |
| scale_dat | input | 1 | Scale data line, asynchronous level |
| out_valid | output | 1 | Position words pending |
| out_ready | input | 1 | Consumer takes the pending words |
| abs_pos | output | 24 | Absolute position word |
| rel_pos | output | 24 | Relative (displayed) position word |
| frame_err | output | 1 | One-cycle pulse when a burst ends early |

## Verification
The assertions check the cycle-level rules on every cycle: words held stable under back-pressure, a frame start only after a qualified gap, completion only on a falling edge, and the single-cycle error pulse. Bit ordering, the split into absolute and relative words, overwriting of pending words, and the need for an idle period before arming can only be shown by the bench's scenarios. The bench sweeps walking-one and arithmetic patterns and compares the output against words it assembles itself.

// File: rtl/cal_rx_pkg.sv
package cal_rx_pkg;
  typedef enum logic [1:0] {
    RX_UNSYNC = 2'd0,
    RX_ARMED  = 2'd1,
    RX_SHIFT  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/cal_rx_sync.sv
module cal_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/cal_rx_timer.sv
module cal_rx_timer #(
  parameter int IDLE_CYC = 250000,
  parameter int GAP_CYC  = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  output logic fall,
  output logic gap_ok,
  output logic idle_ok
);
  localparam int LO_W = $clog2(IDLE_CYC + 1);
  localparam int HI_W = $clog2(GAP_CYC + 1);
  localparam logic [LO_W-1:0] LO_MAX = LO_W'(IDLE_CYC);
  localparam logic [HI_W-1:0] HI_MAX = HI_W'(GAP_CYC);

  logic            prev;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      prev <= line_s;
      if (line_s) begin
        lo_cnt <= '0;
        if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  assign fall    = prev & ~line_s;
  assign gap_ok  = (hi_cnt == HI_MAX);
  assign idle_ok = (lo_cnt == LO_MAX);
endmodule

// File: rtl/cal_rx_frame.sv
module cal_rx_frame
  import cal_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              gap_ok,
  input  logic              idle_ok,
  input  logic              dat_s,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] abs_w,
  output logic [WORD_W-1:0] rel_w
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  rx_state_t          st;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_UNSYNC;
      bit_cnt <= '0;
      sr      <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        RX_UNSYNC: begin
          if (idle_ok) st <= RX_ARMED;
        end
        RX_ARMED: begin
          if (fall && gap_ok) begin
            sr      <= {dat_s, sr[FRAME_W-1:1]};
            bit_cnt <= BIT_W'(1);
            st      <= RX_SHIFT;
          end
        end
        RX_SHIFT: begin
          if (idle_ok) begin
            err     <= 1'b1;
            bit_cnt <= '0;
            st      <= RX_ARMED;
          end else if (fall) begin
            sr <= {dat_s, sr[FRAME_W-1:1]};
            if (bit_cnt == LAST_BIT) begin
              done    <= 1'b1;
              bit_cnt <= '0;
              st      <= RX_UNSYNC;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: st <= RX_UNSYNC;
      endcase
    end
  end

  assign abs_w = sr[WORD_W-1:0];
  assign rel_w = sr[FRAME_W-1:WORD_W];

  // R3: a frame begins only on a falling edge after a qualified gap
  p_start_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_SHIFT && $past(st) == RX_ARMED) |-> $past(fall && gap_ok));

  // R5: completion is always the result of a falling edge
  p_done_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall));

  // R9: the error indication lasts one cycle
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

// File: rtl/cal_rx_out.sv
module cal_rx_out #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] abs_in,
  input  logic [WORD_W-1:0] rel_in,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] abs_out,
  output logic [WORD_W-1:0] rel_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      abs_out <= '0;
      rel_out <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      abs_out <= abs_in;
      rel_out <= rel_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R6: pending words are held under back-pressure
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);

  p_words_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> ($stable(abs_out) && $stable(rel_out)));
endmodule

// File: rtl/cal_bin_rx.sv
module cal_bin_rx #(
  parameter int WORD_W   = 24,
  parameter int STAGES   = 2,
  parameter int IDLE_CYC = 250000,
  parameter int GAP_CYC  = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scale_clk,
  input  logic              scale_dat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] abs_pos,
  output logic [WORD_W-1:0] rel_pos,
  output logic              frame_err
);
  logic [1:0]        lines_s;
  logic              fall, gap_ok, idle_ok, done;
  logic [WORD_W-1:0] abs_w, rel_w;

  cal_rx_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({scale_dat, scale_clk}),
    .sync_out(lines_s)
  );

  cal_rx_timer #(.IDLE_CYC(IDLE_CYC), .GAP_CYC(GAP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_s(lines_s[0]),
    .fall(fall), .gap_ok(gap_ok), .idle_ok(idle_ok)
  );

  cal_rx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .fall(fall), .gap_ok(gap_ok),
    .idle_ok(idle_ok), .dat_s(lines_s[1]),
    .done(done), .err(frame_err), .abs_w(abs_w), .rel_w(rel_w)
  );

  cal_rx_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .abs_in(abs_w), .rel_in(rel_w),
    .ready(out_ready), .valid(out_valid), .abs_out(abs_pos), .rel_out(rel_pos)
  );

  // R9: an aborted frame never raises the output strobe at the same time
  p_err_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !done);
endmodule

// File: tb/sim_cal_bin_rx.sv
`timescale 1ns/1ps
module sim_cal_bin_rx;
  localparam int IDLE = 40;
  localparam int GAP  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_clk = 1'b1;
  logic sc_dat = 1'b0;
  logic ready = 1'b0;
  logic valid, ferr;
  logic [23:0] abs_pos, rel_pos;

  int checks = 0;
  int fails = 0;
  int err_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cal_bin_rx #(.WORD_W(24), .STAGES(2), .IDLE_CYC(IDLE), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .scale_clk(sc_clk), .scale_dat(sc_dat),
    .out_valid(valid), .out_ready(ready), .abs_pos(abs_pos),
    .rel_pos(rel_pos), .frame_err(ferr)
  );

  always @(negedge clk) if (ferr) err_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [47:0] f, input int nbits, input int gap);
    sc_clk = 1'b1;
    hold(gap);
    for (int i = 0; i < nbits; i++) begin
      sc_dat = f[i];
      hold(2);
      sc_clk = 1'b0;
      hold(4);
      if (i != nbits - 1) begin
        sc_clk = 1'b1;
        hold(2);
      end
    end
    sc_clk = 1'b0;
  endtask

  task automatic frame(input logic [23:0] a, input logic [23:0] r);
    sc_clk = 1'b0;
    hold(IDLE + 20);
    send_bits({r, a}, 48, GAP + 8);
    hold(10);
  endtask

  task automatic accept(input string req);
    ready = 1'b1;
    hold(1);
    ready = 1'b0;
    hold(1);
    chk(req, {31'd0, valid}, 32'd0);
  endtask

  task automatic expect_words(input logic [23:0] a, input logic [23:0] r);
    chk("R5 valid", {31'd0, valid}, 32'd1);
    chk("R4 abs", {8'd0, abs_pos}, {8'd0, a});
    chk("R4 rel", {8'd0, rel_pos}, {8'd0, r});
  endtask

  initial begin
    int errs0;
    logic [23:0] a, r;
    hold(3);
    rst_n = 1'b1;
    hold(1);
    // R1 reset state
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 err", {31'd0, ferr}, 32'd0);
    chk("R1 abs", {8'd0, abs_pos}, 32'd0);
    chk("R1 rel", {8'd0, rel_pos}, 32'd0);

    // R2: burst with no preceding idle is ignored
    send_bits({24'h123456, 24'hABCDEF}, 48, GAP + 8);
    hold(10);
    chk("R2 no idle", {31'd0, valid}, 32'd0);

    // R4 R5 R8: walking ones in abs, arithmetic rel
    for (int k = 0; k < 24; k++) begin
      a = 24'd1 << k;
      r = 24'((k * 32'h2A5B1 + 7) & 32'hFFFFFF);
      frame(a, r);
      expect_words(a, r);
      accept("R8 consumed");
    end
    // walking ones in rel
    for (int k = 0; k < 24; k += 3) begin
      a = 24'((k * 32'h13579 + 32'h800000) & 32'hFFFFFF);
      r = 24'd1 << k;
      frame(a, r);
      expect_words(a, r);
      accept("R8 consumed");
    end
    frame(24'hFFFFFF, 24'h000000);
    expect_words(24'hFFFFFF, 24'h000000);
    accept("R8 consumed");
    frame(24'h555555, 24'hAAAAAA);
    expect_words(24'h555555, 24'hAAAAAA);
    accept("R8 consumed");

    // R3: short pulses while armed are ignored
    sc_clk = 1'b0;
    hold(IDLE + 20);
    for (int p = 0; p < 5; p++) begin
      sc_dat = p[0];
      sc_clk = 1'b1; hold(GAP - 6);
      sc_clk = 1'b0; hold(4);
    end
    send_bits({24'h0F0F0F, 24'h3C3C3C}, 48, GAP + 4);
    hold(10);
    chk("R3 valid", {31'd0, valid}, 32'd1);
    chk("R3 abs", {8'd0, abs_pos}, 32'h3C3C3C);
    chk("R3 rel", {8'd0, rel_pos}, 32'h0F0F0F);
    accept("R8 consumed");

    // R2: after a frame, a burst without a fresh idle is ignored
    hold(8);
    send_bits({24'h111111, 24'h222222}, 48, GAP + 8);
    hold(10);
    chk("R2 resync", {31'd0, valid}, 32'd0);

    // R6 R7: hold under back-pressure, then overwrite
    frame(24'h00ABCD, 24'h00FEED);
    hold(30);
    chk("R6 hold valid", {31'd0, valid}, 32'd1);
    chk("R6 hold abs", {8'd0, abs_pos}, 32'h00ABCD);
    chk("R6 hold rel", {8'd0, rel_pos}, 32'h00FEED);
    frame(24'h654321, 24'h0C0FFE);
    chk("R7 valid", {31'd0, valid}, 32'd1);
    chk("R7 abs", {8'd0, abs_pos}, 32'h654321);
    chk("R7 rel", {8'd0, rel_pos}, 32'h0C0FFE);
    accept("R8 consumed");

    // R9: partial frames
    errs0 = err_seen;
    sc_clk = 1'b0;
    hold(IDLE + 20);
    send_bits({24'hFFFFFF, 24'hFFFFFF}, 30, GAP + 8);
    hold(IDLE + 20);
    chk("R9 err count", 32'(err_seen - errs0), 32'd1);
    chk("R9 no valid", {31'd0, valid}, 32'd0);
    send_bits({24'h0, 24'h0}, 47, GAP + 8);
    hold(IDLE + 20);
    chk("R9 err count 47", 32'(err_seen - errs0), 32'd2);
    chk("R9 no valid 47", {31'd0, valid}, 32'd0);
    // armed directly after an error: a burst works without extra idle
    send_bits({24'h000777, 24'h999000}, 48, GAP + 8);
    hold(10);
    expect_words(24'h999000, 24'h000777);
    chk("R9 no extra err", 32'(err_seen - errs0), 32'd2);
    accept("R8 consumed");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule